// File: doc/BRIEF.md
# Audio clock tree controller

This block turns source clock-enable strobes into three divided, gated clock enables for an audio subsystem: one system clock enable and one bit-clock enable for each of two serial ports. All outputs are single-cycle pulses in the fast clock domain. One internal strobe comes from an audio PLL. Each serial port also has an external I2S clock strobe. A single 32-bit control register, written over a simple register bus, sets every mux, divider and gate.

Each serial port has a one-bit source select, a 6-bit divider and a gate. The system clock path has its own divider and gate. It has no mux of its own and counts whatever strobe port 0's mux selects. Divider codes count from one, so code N divides by N. Code zero is legal and behaves like code one.

Ratio and gate changes are held back until the running divide period ends. A period is therefore never cut short, and a partial one never appears.

Top module: `audclk_tree`

## Requirements
- R1: The control register sits at byte offset 0x04 and reads back the last value written there. Reset clears it to zero. A write to any other offset changes nothing, and a read of any other offset returns zero.
- R2: Port 0's source select is bit 7 and port 1's is bit 23. Value 0 selects the PLL strobe and value 1 selects that port's external strobe. A change of select takes effect on the next strobe.
- R3: The system path gate is bit 0 and its divider is bits 6:1. It counts the strobe chosen by port 0's select.
- R4: Port 0's gate is bit 8 and its divider is bits 14:9.
- R5: Port 1's gate is bit 16 and its divider is bits 22:17.
- R6: With divider code N from 1 to 63, an enabled path emits one pulse for every N strobes of its source, on the Nth strobe. Code 0 behaves exactly like code 1.
- R7: A path whose gate is 0 emits no pulses. A gate change written during a period takes effect only from the next period boundary.
- R8: A new divider code is adopted only when the current period ends, so the period already running completes at its old length.
- R9: Each output pulse is one cycle wide and appears in the cycle after the clock edge that samples the strobe completing the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from the address |
| pllTick | input | 1 | PLL-derived source strobe |
| extTick0 | input | 1 | External I2S source strobe for port 0 |
| extTick1 | input | 1 | External I2S source strobe for port 1 |
| sysClkEn | output | 1 | System clock enable pulse |
| port0ClkEn | output | 1 | Port 0 bit-clock enable pulse |
| port1ClkEn | output | 1 | Port 1 bit-clock enable pulse |

## Verification
Some properties are checked on every cycle. Each pulse must follow a strobe on the source that path selects, and the system path must follow port 0's selected source. The held ratio and gate may change only at a period wrap, and each counter stays within its held ratio. Register writes either land or leave the register untouched.

Other properties only the directed scenarios can show. These are the actual pulse counts and phases for given divider codes, the equivalence of code zero and code one, and the 63 boundary. They also include where each field sits in the register word, and the exact period in which a written gate or ratio first takes hold.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int DATA_W   = 32;
  localparam int DIV_W    = 6;
  localparam int NUM_CHAN = 3;

  // field positions within the control word
  localparam int SYS_GATE_BIT = 0;
  localparam int SYS_DIV_LSB  = 1;
  localparam int P0_SEL_BIT   = 7;
  localparam int P0_GATE_BIT  = 8;
  localparam int P0_DIV_LSB   = 9;
  localparam int P1_GATE_BIT  = 16;
  localparam int P1_DIV_LSB   = 17;
  localparam int P1_SEL_BIT   = 23;

  typedef enum int {CH_SYS = 0, CH_P0 = 1, CH_P1 = 2} chanIdx_e;

  typedef struct packed {
    logic             gate;
    logic [DIV_W-1:0] ratio;
  } chanCfg_t;

  typedef struct packed {
    logic [1:0]                  srcSel;
    chanCfg_t [NUM_CHAN-1:0]     chan;
  } treeCfg_t;
endpackage

// File: rtl/audclk_regs.sv
module audclk_regs
  import audclk_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output treeCfg_t          cfg
);
  logic [DATA_W-1:0] ctrlReg;
  logic              addrHit;

  assign addrHit = (busAddr == CTRL_OFFSET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   ctrlReg <= '0;
    else if (busWrEn && addrHit) ctrlReg <= busWrData;
  end

  assign busRdData = addrHit ? ctrlReg : '0;

  always_comb begin
    cfg = '0;
    cfg.srcSel[0]          = ctrlReg[P0_SEL_BIT];
    cfg.srcSel[1]          = ctrlReg[P1_SEL_BIT];
    cfg.chan[CH_SYS].gate  = ctrlReg[SYS_GATE_BIT];
    cfg.chan[CH_SYS].ratio = ctrlReg[SYS_DIV_LSB +: DIV_W];
    cfg.chan[CH_P0].gate   = ctrlReg[P0_GATE_BIT];
    cfg.chan[CH_P0].ratio  = ctrlReg[P0_DIV_LSB +: DIV_W];
    cfg.chan[CH_P1].gate   = ctrlReg[P1_GATE_BIT];
    cfg.chan[CH_P1].ratio  = ctrlReg[P1_DIV_LSB +: DIV_W];
  end

  // R1
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && addrHit) |=> (ctrlReg == $past(busWrData)));
  // R1
  wr_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && addrHit) |=> $stable(ctrlReg));
endmodule

// File: rtl/audclk_divgate.sv
module audclk_divgate
  import audclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             cfgGate,
  input  logic [DIV_W-1:0] cfgRatio,
  output logic             pulseOut
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lastIdx;
  logic             gateLive;
  logic             wrap;
  logic [DIV_W-1:0] nextLast;

  assign wrap     = tickIn && (cnt == lastIdx);
  assign nextLast = (cfgRatio == '0) ? '0 : cfgRatio - DIV_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      lastIdx  <= '0;
      gateLive <= 1'b0;
      pulseOut <= 1'b0;
    end else begin
      pulseOut <= wrap && gateLive;
      if (wrap) begin
        cnt      <= '0;
        lastIdx  <= nextLast;
        gateLive <= cfgGate;
      end else if (tickIn) begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastIdx);
  // R8
  ratio_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(tickIn && (cnt == lastIdx)) |=> $stable(lastIdx));
  // R7
  gate_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(tickIn && (cnt == lastIdx)) |=> $stable(gateLive));
  // R9
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |-> $past(tickIn));
endmodule

// File: rtl/audclk_paths.sv
module audclk_paths
  import audclk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                pllTick,
  input  logic [1:0]          extTick,
  input  treeCfg_t            cfg,
  output logic [NUM_CHAN-1:0] clkEn
);
  logic [1:0]          portSrc;
  logic [NUM_CHAN-1:0] chanTick;

  generate
    for (genvar p = 0; p < 2; p++) begin : g_mux
      assign portSrc[p] = cfg.srcSel[p] ? extTick[p] : pllTick;
    end
  endgenerate

  // system path shares port 0's mux output
  assign chanTick[CH_SYS] = portSrc[0];
  assign chanTick[CH_P0]  = portSrc[0];
  assign chanTick[CH_P1]  = portSrc[1];

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      audclk_divgate u_div (
        .clk      (clk),
        .rstN     (rstN),
        .tickIn   (chanTick[c]),
        .cfgGate  (cfg.chan[c].gate),
        .cfgRatio (cfg.chan[c].ratio),
        .pulseOut (clkEn[c])
      );
    end
  endgenerate

  // R3
  sys_follows_p0_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn[CH_SYS] |-> $past(cfg.srcSel[0] ? extTick[0] : pllTick));
  // R2
  p1_follows_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn[CH_P1] |-> $past(cfg.srcSel[1] ? extTick[1] : pllTick));
endmodule

// File: rtl/audclk_tree.sv
module audclk_tree
  import audclk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              pllTick,
  input  logic              extTick0,
  input  logic              extTick1,
  output logic              sysClkEn,
  output logic              port0ClkEn,
  output logic              port1ClkEn
);
  treeCfg_t            cfg;
  logic [NUM_CHAN-1:0] clkEn;

  audclk_regs #(.ADDR_W(ADDR_W), .CTRL_OFFSET(ADDR_W'(4))) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .cfg       (cfg)
  );

  audclk_paths u_paths (
    .clk     (clk),
    .rstN    (rstN),
    .pllTick (pllTick),
    .extTick ({extTick1, extTick0}),
    .cfg     (cfg),
    .clkEn   (clkEn)
  );

  assign sysClkEn   = clkEn[CH_SYS];
  assign port0ClkEn = clkEn[CH_P0];
  assign port1ClkEn = clkEn[CH_P1];
endmodule

// File: tb/audclk_tree_tb.sv
module audclk_tree_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        pllTick = 1'b0, extTick0 = 1'b0, extTick1 = 1'b0;
  logic        sysClkEn, port0ClkEn, port1ClkEn;

  int checks = 0, failures = 0;
  int nSys = 0, nP0 = 0, nP1 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audclk_tree u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pllTick(pllTick),
    .extTick0(extTick0), .extTick1(extTick1), .sysClkEn(sysClkEn),
    .port0ClkEn(port0ClkEn), .port1ClkEn(port1ClkEn)
  );

  // field layout per R2..R5
  function automatic logic [31:0] mk(bit sysG, int sysD, bit sel0, bit p0G, int p0D,
                                     bit p1G, int p1D, bit sel1);
    logic [31:0] v = '0;
    v[0] = sysG; v[6:1] = 6'(sysD); v[7] = sel0; v[8] = p0G;
    v[14:9] = 6'(p0D); v[16] = p1G; v[22:17] = 6'(p1D); v[23] = sel1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pllTick = 0; extTick0 = 0; extTick1 = 0; busWrEn = 0;
    @(negedge clk);
    rstN = 1'b1;
    nSys = 0; nP0 = 0; nP1 = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic tick(input bit p, input bit e0, input bit e1);
    @(negedge clk);
    if (sysClkEn || port0ClkEn || port1ClkEn) begin
      failures++; checks++;
      $display("FAIL R9 pulse wider than one cycle act=%b%b%b exp=000",
               sysClkEn, port0ClkEn, port1ClkEn);
    end
    pllTick = p; extTick0 = e0; extTick1 = e1;
    @(negedge clk);
    pllTick = 0; extTick0 = 0; extTick1 = 0;
    if (sysClkEn)   nSys++;
    if (port0ClkEn) nP0++;
    if (port1ClkEn) nP1++;
  endtask

  task automatic ticks(input int n, input bit p, input bit e0, input bit e1);
    for (int i = 0; i < n; i++) tick(p, e0, e1);
  endtask

  task automatic zero();
    nSys = 0; nP0 = 0; nP1 = 0;
  endtask

  // one strobe on every source: each path ends its reset period and loads config
  task automatic prime();
    tick(1, 1, 1);
    check(nSys == 0 && nP0 == 0 && nP1 == 0, "R7 prime period gated", nSys + nP0 + nP1, 0);
    zero();
  endtask

  task automatic testReset();
    doReset();
    busAddr = 8'h04;
    @(negedge clk);
    check(busRdData == 32'h0, "R1 reset value", int'(busRdData), 0);
    check(!sysClkEn && !port0ClkEn && !port1ClkEn, "R9 outputs low in reset", 0, 0);
  endtask

  task automatic testRegAccess();
    doReset();
    wr(8'h04, 32'h00A5_5A5A);
    busAddr = 8'h04; #1;
    check(busRdData == 32'h00A5_5A5A, "R1 readback", int'(busRdData), 32'h00A5_5A5A);
    wr(8'h08, 32'hFFFF_FFFF);
    busAddr = 8'h08; #1;
    check(busRdData == 32'h0, "R1 other offset reads zero", int'(busRdData), 0);
    busAddr = 8'h04; #1;
    check(busRdData == 32'h00A5_5A5A, "R1 other offset write ignored", int'(busRdData), 32'h00A5_5A5A);
  endtask

  task automatic testDivide();
    int firstP0 = -1;
    doReset();
    wr(8'h04, mk(1, 2, 0, 1, 3, 1, 5, 0));
    prime();
    for (int i = 1; i <= 30; i++) begin
      tick(1, 0, 0);
      if (firstP0 < 0 && nP0 == 1) firstP0 = i;
    end
    check(nSys == 15, "R3 sys divide by 2", nSys, 15);
    check(nP0 == 10, "R4 port0 divide by 3", nP0, 10);
    check(nP1 == 6, "R5 port1 divide by 5", nP1, 6);
    check(firstP0 == 3, "R6 pulse on Nth strobe", firstP0, 3);
  endtask

  task automatic testZeroCode();
    doReset();
    wr(8'h04, mk(1, 0, 0, 1, 1, 1, 0, 0));
    prime();
    ticks(7, 1, 0, 0);
    check(nSys == 7, "R6 code 0 sys", nSys, 7);
    check(nP0 == 7, "R6 code 1 port0", nP0, 7);
    check(nP1 == 7, "R6 code 0 port1", nP1, 7);
  endtask

  task automatic testMaxCode();
    doReset();
    wr(8'h04, mk(0, 0, 0, 0, 0, 1, 63, 0));
    prime();
    ticks(62, 1, 0, 0);
    check(nP1 == 0, "R6 63 not yet", nP1, 0);
    tick(1, 0, 0);
    check(nP1 == 1, "R6 63rd strobe", nP1, 1);
    ticks(63, 1, 0, 0);
    check(nP1 == 2, "R6 second 63 period", nP1, 2);
  endtask

  task automatic testMux();
    doReset();
    wr(8'h04, mk(1, 2, 1, 1, 3, 1, 1, 0));
    prime();
    ticks(6, 1, 0, 0);
    check(nSys == 0 && nP0 == 0, "R2 port0 ignores pll when external", nSys + nP0, 0);
    check(nP1 == 6, "R2 port1 on pll", nP1, 6);
    zero();
    ticks(6, 0, 1, 0);
    check(nSys == 3, "R3 sys fed by port0 external", nSys, 3);
    check(nP0 == 2, "R2 port0 external", nP0, 2);
    check(nP1 == 0, "R2 port1 ignores ext0", nP1, 0);
    zero();
    ticks(4, 0, 0, 1);
    check(nP1 == 0, "R2 port1 ignores ext1 when pll selected", nP1, 0);
    wr(8'h04, mk(1, 2, 1, 1, 3, 1, 1, 1));
    ticks(4, 0, 0, 1);
    check(nP1 == 4, "R2 port1 external after select", nP1, 4);
  endtask

  task automatic testGate();
    doReset();
    wr(8'h04, mk(0, 1, 0, 0, 1, 0, 1, 0));
    prime();
    ticks(5, 1, 0, 0);
    check(nSys + nP0 + nP1 == 0, "R7 gates off", nSys + nP0 + nP1, 0);
    doReset();
    wr(8'h04, mk(0, 0, 0, 1, 4, 0, 0, 0));
    prime();
    ticks(2, 1, 0, 0);
    wr(8'h04, mk(0, 0, 0, 0, 4, 0, 0, 0));
    ticks(2, 1, 0, 0);
    check(nP0 == 1, "R7 gate-off waits for boundary", nP0, 1);
    ticks(4, 1, 0, 0);
    check(nP0 == 1, "R7 gate-off next period", nP0, 1);
    ticks(2, 1, 0, 0);
    wr(8'h04, mk(0, 0, 0, 1, 4, 0, 0, 0));
    ticks(2, 1, 0, 0);
    check(nP0 == 1, "R7 gate-on waits for boundary", nP0, 1);
    ticks(4, 1, 0, 0);
    check(nP0 == 2, "R7 gate-on next period", nP0, 2);
  endtask

  task automatic testReload();
    doReset();
    wr(8'h04, mk(0, 0, 0, 1, 4, 0, 0, 0));
    prime();
    tick(1, 0, 0);
    wr(8'h04, mk(0, 0, 0, 1, 2, 0, 0, 0));
    ticks(2, 1, 0, 0);
    check(nP0 == 0, "R8 old period not truncated", nP0, 0);
    tick(1, 0, 0);
    check(nP0 == 1, "R8 old period completes", nP0, 1);
    ticks(4, 1, 0, 0);
    check(nP0 == 3, "R8 new ratio applied", nP0, 3);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testReset();
    testRegAccess();
    testDivide();
    testZeroCode();
    testMaxCode();
    testMux();
    testGate();
    testReload();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule